// File: doc/BRIEF.md
# Half-Group Word Access Coalescer

This block sits between a 16-lane load/store issue stage and the memory port. It takes one request from a group of 16 lanes. Each lane has an enable bit and a 32-bit byte address of a 4-byte word. The block turns that request into the smallest set of 64-byte segment transactions that its rule set allows. It hands these out one per cycle on a valid/ready port. Each transaction carries a segment base address and a mask of the lanes it serves. Data movement is not part of the block.

A mode bit chosen per request picks one of two rule sets. The strict rule merges the group into a single transaction only when every enabled lane k targets byte offset 4k of one aligned segment. Any other pattern falls back to one transaction per enabled lane. The relaxed rule merges all lanes that share a segment, whatever their order, and emits the segments from the lowest address to the highest.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, txn_valid_o is 0 and req_ready_o is 1.
- R2: Mode value 0 selects the strict rule and mode value 1 selects the relaxed rule. The mode is captured with the request.
- R3: In strict mode, when every enabled lane k has address[5:0] == 4*k and all enabled lanes share address[31:6], exactly one transaction is emitted. Its base is {address[31:6], 6'b0} and its mask equals the enable mask.
- R4: In strict mode, disabled lanes never prevent the single merged transaction.
- R5: In strict mode, any other pattern (permuted lanes, misaligned start, mixed segments) emits one transaction per enabled lane. These go in ascending lane order, each with a one-hot mask (bit k = lane k) and the base of that lane's own 64-byte segment.
- R6: In relaxed mode, one transaction is emitted per distinct 64-byte segment touched by enabled lanes. Its mask holds exactly the enabled lanes whose address lies in that segment.
- R7: In relaxed mode, transactions leave in strictly ascending base address order. A run of consecutive words that crosses a segment boundary yields two transactions.
- R8: txn_last_o is 1 on the final transaction of a request and 0 on all others.
- R9: While txn_valid_o is 1 and txn_ready_i is 0, txn_valid_o, txn_base_o and txn_mask_o hold their values.
- R10: req_ready_o is 0 from acceptance until the last transaction is handed off. It is 1 in the cycle after that handoff.
- R11: A request with no enabled lanes is accepted and produces no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request is taken on this edge |
| req_mode_i | input | 1 | 0 strict rule, 1 relaxed rule |
| req_active_i | input | 16 | Lane enable bits, bit k = lane k |
| req_addr_i | input | 512 | Lane byte addresses, lane k at bits [32k+31:32k] |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Memory port takes the transaction |
| txn_base_o | output | 32 | 64-byte aligned segment base |
| txn_mask_o | output | 16 | Lanes served by this transaction |
| txn_last_o | output | 1 | Final transaction of the request |

## Verification
The hardest case to reach is a strict-mode request that is almost coalescible. All enabled lanes sit in one aligned segment, but a single lane is off its slot, or a pattern is correct but shifted by one word. Such a request has to fall back completely. The bench builds these from a sequential base pattern and perturbs it: it swaps two lanes, shifts the start by 4 bytes, or thins the enable mask. It then runs long random sweeps of addresses confined to three neighbouring segments, with random back-pressure, so that every request also exercises holding under stall.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    MODE_STRICT  = 1'b0,
    MODE_RELAXED = 1'b1
  } coal_mode_e;
endpackage

// File: rtl/coal_strict_check.sv
module coal_strict_check #(
  parameter int LANES      = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SEG_BYTES  = 64
) (
  input  logic [LANES-1:0]    active_i,
  input  logic [LANES*AW-1:0] addr_i,
  output logic                coalesce_o
);
  localparam int OFFW = $clog2(SEG_BYTES);
  localparam int SEGW = AW - OFFW;

  logic [SEGW-1:0] ref_seg;

  always_comb begin
    // segment of the lowest enabled lane is the reference
    ref_seg = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (active_i[k]) ref_seg = addr_i[k*AW+OFFW +: SEGW];
    end
    coalesce_o = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (active_i[k]) begin
        if (addr_i[k*AW +: OFFW] != OFFW'(k * WORD_BYTES)) coalesce_o = 1'b0;
        if (addr_i[k*AW+OFFW +: SEGW] != ref_seg) coalesce_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64
) (
  input  logic [LANES-1:0]                   pend_i,
  input  logic [LANES*AW-1:0]                addr_i,
  output logic [AW-$clog2(SEG_BYTES)-1:0]    seg_o,
  output logic [LANES-1:0]                   mask_o
);
  localparam int OFFW = $clog2(SEG_BYTES);
  localparam int SEGW = AW - OFFW;

  logic [SEGW-1:0] min_seg;

  always_comb begin
    min_seg = '1;
    for (int k = 0; k < LANES; k++) begin
      if (pend_i[k] && (addr_i[k*AW+OFFW +: SEGW] < min_seg))
        min_seg = addr_i[k*AW+OFFW +: SEGW];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign mask_o[g] = pend_i[g] && (addr_i[g*AW+OFFW +: SEGW] == min_seg);
  end

  assign seg_o = min_seg;
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 64
) (
  input  logic [LANES-1:0]                   pend_i,
  input  logic [LANES*AW-1:0]                addr_i,
  output logic [AW-$clog2(SEG_BYTES)-1:0]    seg_o,
  output logic [LANES-1:0]                   mask_o
);
  localparam int OFFW = $clog2(SEG_BYTES);
  localparam int SEGW = AW - OFFW;

  assign mask_o = pend_i & (~pend_i + LANES'(1));

  always_comb begin
    seg_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (mask_o[k]) seg_o = addr_i[k*AW+OFFW +: SEGW];
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SEG_BYTES  = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_mode_i,
  input  logic [LANES-1:0]    req_active_i,
  input  logic [LANES*AW-1:0] req_addr_i,
  output logic                txn_valid_o,
  input  logic                txn_ready_i,
  output logic [AW-1:0]       txn_base_o,
  output logic [LANES-1:0]    txn_mask_o,
  output logic                txn_last_o
);
  import coal_pkg::*;

  localparam int OFFW = $clog2(SEG_BYTES);
  localparam int SEGW = AW - OFFW;

  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  coal_mode_e          mode_q;
  logic                coal_q;

  logic                strict_ok;
  logic [SEGW-1:0]     grp_seg, lane_seg, sel_seg;
  logic [LANES-1:0]    grp_mask, lane_mask, sel_mask;
  logic                accept, fire;

  coal_strict_check #(
    .LANES(LANES), .AW(AW), .WORD_BYTES(WORD_BYTES), .SEG_BYTES(SEG_BYTES)
  ) u_strict (
    .active_i  (req_active_i),
    .addr_i    (req_addr_i),
    .coalesce_o(strict_ok)
  );

  coal_seg_pick #(
    .LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)
  ) u_seg (
    .pend_i(pend_q),
    .addr_i(addr_q),
    .seg_o (grp_seg),
    .mask_o(grp_mask)
  );

  coal_lane_pick #(
    .LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)
  ) u_lane (
    .pend_i(pend_q),
    .addr_i(addr_q),
    .seg_o (lane_seg),
    .mask_o(lane_mask)
  );

  // strict-coalesced and relaxed both take the min-segment group
  always_comb begin
    if (mode_q == MODE_STRICT && !coal_q) begin
      sel_mask = lane_mask;
      sel_seg  = lane_seg;
    end else begin
      sel_mask = grp_mask;
      sel_seg  = grp_seg;
    end
  end

  assign req_ready_o = (pend_q == '0);
  assign accept      = req_valid_i && req_ready_o;
  assign txn_valid_o = (pend_q != '0);
  assign fire        = txn_valid_o && txn_ready_i;
  assign txn_mask_o  = sel_mask;
  assign txn_base_o  = {sel_seg, {OFFW{1'b0}}};
  assign txn_last_o  = ((pend_q & ~sel_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      addr_q <= '0;
      mode_q <= MODE_STRICT;
      coal_q <= 1'b0;
    end else if (accept) begin
      pend_q <= req_active_i;
      addr_q <= req_addr_i;
      mode_q <= coal_mode_e'(req_mode_i);
      coal_q <= strict_ok;
    end else if (fire) begin
      pend_q <= pend_q & ~sel_mask;
    end
  end

  a_r6_mask_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_mask_o != '0) && ((txn_mask_o & ~pend_q) == '0));

  a_r3_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && mode_q == MODE_STRICT && coal_q) |-> txn_last_o);

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && mode_q == MODE_STRICT && !coal_q) |-> ($countones(txn_mask_o) == 1));

  a_r5_lane_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !txn_last_o && mode_q == MODE_STRICT && !coal_q) |=> (txn_mask_o > $past(txn_mask_o)));

  a_r7_seg_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !txn_last_o && mode_q == MODE_RELAXED) |=> (txn_base_o > $past(txn_base_o)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_o && !txn_ready_i) |=> txn_valid_o && $stable(txn_base_o) && $stable(txn_mask_o));

  a_r10_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && txn_last_o) |=> req_ready_o);
endmodule

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic                req_mode = 1'b0;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                txn_valid;
  logic                txn_ready = 1'b0;
  logic [AW-1:0]       txn_base;
  logic [LANES-1:0]    txn_mask;
  logic                txn_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [AW-1:0]    la[LANES];
  logic [AW-1:0]    exp_base[LANES];
  logic [LANES-1:0] exp_mask[LANES];
  int               exp_n;

  always #2.5 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_mode_i(req_mode), .req_active_i(req_active), .req_addr_i(req_addr),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_base_o(txn_base), .txn_mask_o(txn_mask), .txn_last_o(txn_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] segb(input logic [AW-1:0] a);
    return {a[AW-1:6], 6'b0};
  endfunction

  // expected transaction list from the requirements
  task automatic build_exp(input bit mode, input logic [LANES-1:0] act);
    logic [LANES-1:0] left;
    bit ok;
    int first;
    exp_n = 0;
    if (act == '0) return;
    if (!mode) begin
      ok = 1'b1;
      first = -1;
      for (int k = 0; k < LANES; k++) if (act[k]) begin
        if (first < 0) first = k;
        if (la[k][5:0] != 6'(4*k)) ok = 1'b0;
        if (segb(la[k]) != segb(la[first])) ok = 1'b0;
      end
      if (ok) begin
        exp_base[0] = segb(la[first]); exp_mask[0] = act; exp_n = 1;
      end else begin
        for (int k = 0; k < LANES; k++) if (act[k]) begin
          exp_base[exp_n] = segb(la[k]);
          exp_mask[exp_n] = LANES'(1) << k;
          exp_n++;
        end
      end
    end else begin
      left = act;
      while (left != '0) begin
        logic [AW-1:0] mn;
        mn = '1;
        for (int k = 0; k < LANES; k++) if (left[k] && segb(la[k]) < mn) mn = segb(la[k]);
        exp_base[exp_n] = mn;
        exp_mask[exp_n] = '0;
        for (int k = 0; k < LANES; k++) if (left[k] && segb(la[k]) == mn) exp_mask[exp_n][k] = 1'b1;
        left &= ~exp_mask[exp_n];
        exp_n++;
      end
    end
  endtask

  task automatic run_req(input bit mode, input logic [LANES-1:0] act, input string tag, input bit stall);
    int got;
    int cyc;
    bit prev_stall;
    logic [AW-1:0] pb;
    logic [LANES-1:0] pm;
    build_exp(mode, act);
    for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = la[k];
    req_mode = mode;
    req_active = act;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10 idle ready", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    cyc = 0;
    prev_stall = 1'b0;
    pb = '0;
    pm = '0;
    while (got < exp_n && cyc < 200) begin
      cyc++;
      if (prev_stall)
        chk(txn_valid && txn_base == pb && txn_mask == pm, "R9 hold under stall",
            64'({txn_base, txn_mask}), 64'({pb, pm}));
      if (txn_valid) begin
        chk(req_ready == 1'b0, "R10 busy", 64'(req_ready), 64'd0);
        txn_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
        if (txn_ready) begin
          chk(txn_base == exp_base[got], {tag, " base"}, 64'(txn_base), 64'(exp_base[got]));
          chk(txn_mask == exp_mask[got], {tag, " mask"}, 64'(txn_mask), 64'(exp_mask[got]));
          chk(txn_last == (got == exp_n - 1), "R8 last flag", 64'(txn_last), 64'(got == exp_n - 1));
          got++;
        end
        prev_stall = !txn_ready;
        pb = txn_base;
        pm = txn_mask;
      end else begin
        chk(1'b0, {tag, " early end"}, 64'(got), 64'(exp_n));
        got = exp_n;
      end
      @(negedge clk);
    end
    txn_ready = 1'b0;
    chk(txn_valid == 1'b0, {tag, " no extra txn"}, 64'(txn_valid), 64'd0);
    chk(req_ready == 1'b1, "R10 ready after last", 64'(req_ready), 64'd1);
  endtask

  task automatic seq_fill(input logic [AW-1:0] base);
    for (int k = 0; k < LANES; k++) la[k] = base + AW'(4*k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txn_valid == 1'b0, "R1 reset valid", 64'(txn_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // R2: each pattern under both rule sets
      seq_fill(32'h0000_1000);
      run_req(1'(m), 16'hFFFF, m ? "R6 relaxed aligned" : "R3 strict aligned", 1'b0);
      run_req(1'(m), 16'hA5A5, m ? "R6 relaxed sparse" : "R4 strict divergent", 1'b1);
      run_req(1'(m), 16'h0001, m ? "R6 one lane" : "R4 one lane", 1'b0);
      la[3] = 32'h0000_1010; la[4] = 32'h0000_100C;
      run_req(1'(m), 16'hFFFF, m ? "R6 permuted" : "R5 permuted", 1'b1);
      run_req(1'(m), 16'hFFE7, m ? "R6 permuted off" : "R4 permuted lanes off", 1'b0);
      seq_fill(32'h0000_2004);
      run_req(1'(m), 16'hFFFF, m ? "R7 straddle" : "R5 misaligned", 1'b1);
      seq_fill(32'h0000_2020);
      run_req(1'(m), 16'h0FF0, m ? "R7 straddle mid" : "R5 offset", 1'b0);
      run_req(1'(m), 16'h0000, "R11 empty", 1'b0);
    end
    for (int i = 0; i < 300; i++) begin
      bit m;
      logic [LANES-1:0] act;
      m = 1'($urandom_range(0, 1));
      act = 16'($urandom);
      if (i % 4 == 0) begin
        seq_fill(32'h0000_4000 + 32'($urandom_range(0, 3)) * 32'd64);
        if (i % 8 == 0) begin
          int a;
          int b;
          logic [AW-1:0] t;
          a = $urandom_range(0, 15); b = $urandom_range(0, 15);
          t = la[a]; la[a] = la[b]; la[b] = t;
        end
      end else begin
        for (int k = 0; k < LANES; k++)
          la[k] = 32'h0000_4000 + 32'($urandom_range(0, 47)) * 32'd4;
      end
      run_req(m, act, m ? "R6 R7 random relaxed" : "R3 R5 random strict", 1'b1);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule